// File: doc/BRIEF.md
# Configuration Space Access Bridge

This block lets a host reach the configuration registers of a set of targets through two host-visible registers. One is a 32-bit pointer register that holds an enable flag, a bus number, a device/function number and a register offset. The other is a 32-bit data window that the host reads or writes at any of four byte offsets with an access size of 1, 2 or 4 bytes. Every data-window access is turned into at most one qualified configuration request that carries the bus, device/function, byte offset, a byte-enable mask and lane-aligned write data.

The bridge always presents the bus and device/function of the pointer register to the target side. The target side answers combinationally with three flags: present, powered, and "function 0 of this device present". Requests are suppressed when the window is disabled, the target is missing, unpowered or hidden, the offset lies at or past the configuration-space limit, or the access size is illegal. A suppressed read returns all ones. All reads, from either register, return data with a one-cycle valid strobe in the cycle after the access. The parameter `SPACE_BYTES` (4 to 256) sets the configuration-space limit.

Top module: `cfg_window_bridge`

## Requirements
- R1: The pointer register (selected by `hb_sel`=0) is updated only by a write with `hb_off`=0 and `hb_size`=4; writes of other sizes or offsets, and all data-window accesses, leave it unchanged.
- R2: A read with `hb_sel`=0 returns the full 32-bit pointer value at any offset and size.
- R3: Pointer bit 31 is the window enable; while it is 0 a data-window write issues no request and a data-window read returns 0xFFFFFFFF.
- R4: A request carries `req_bus` = pointer[23:16], `req_devfn` = pointer[15:8] and `req_offset` = pointer[7:0] bitwise-ORed with `hb_off` in bits 1:0.
- R5: The request length is the smaller of the access size and `SPACE_BYTES - req_offset`; `req_be` is that many ones starting at bit `req_offset[1:0]`, truncated to 4 bits (bit n enables byte lane n), and `req_wdata` is `hb_wdata` shifted left by 8*`req_offset[1:0]`.
- R6: Every read raises `hb_rvalid` for exactly the next cycle; a granted data-window read returns the target's word shifted right by 8*`req_offset[1:0]`, zero-filled at the top; writes raise no `hb_rvalid`.
- R7: When `tgt_present` is 0, a read returns 0xFFFFFFFF and a write issues no request.
- R8: When the target is unpowered, or its function number (`req_devfn[2:0]`) is non-zero while `tgt_fn0_present` is 0, the access issues no request and a read returns 0xFFFFFFFF; a non-zero function with function 0 present is granted.
- R9: An access whose `req_offset` is at or beyond `SPACE_BYTES` issues no request and a read returns 0xFFFFFFFF.
- R10: A data-window access with a size other than 1, 2 or 4 issues no request and a read returns 0xFFFFFFFF.
- R11: The active-low synchronous reset clears the pointer register to zero and `hb_rvalid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hb_valid | input | 1 | Host access strobe, one cycle per access |
| hb_write | input | 1 | 1 = write, 0 = read |
| hb_sel | input | 1 | 0 = pointer register, 1 = data window |
| hb_off | input | 2 | Byte offset of the access |
| hb_size | input | 3 | Access size in bytes |
| hb_wdata | input | 32 | Host write data, low bytes first |
| hb_rdata | output | 32 | Read data, valid with hb_rvalid |
| hb_rvalid | output | 1 | Read data strobe, cycle after the read |
| req_valid | output | 1 | Configuration request issued this cycle |
| req_write | output | 1 | Request direction |
| req_bus | output | 8 | Bus number |
| req_devfn | output | 8 | Device/function number |
| req_offset | output | 8 | Byte offset in configuration space |
| req_be | output | 4 | Byte-lane enables of the dword |
| req_wdata | output | 32 | Lane-aligned write data |
| req_rdata | input | 32 | Target read word, same cycle as the request |
| tgt_present | input | 1 | Addressed target exists |
| tgt_powered | input | 1 | Addressed target is powered |
| tgt_fn0_present | input | 1 | Function 0 of the addressed device exists |

## Verification
The bench builds the bridge with `SPACE_BYTES` = 64, so the limit falls inside the 8-bit offset field. That makes both the clipping of lengths near offset 63 and the outright suppression of offsets 64 and above reachable with plain pointer values, which the default of 256 would only partly expose. All other behaviour, including the four byte lanes, the ORed offset bits and the target-status suppression, is independent of that value.

// File: rtl/cfg_window_bridge.sv
module cfg_window_bridge #(
  parameter int SPACE_BYTES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hb_valid,
  input  logic        hb_write,
  input  logic        hb_sel,
  input  logic [1:0]  hb_off,
  input  logic [2:0]  hb_size,
  input  logic [31:0] hb_wdata,
  output logic [31:0] hb_rdata,
  output logic        hb_rvalid,
  output logic        req_valid,
  output logic        req_write,
  output logic [7:0]  req_bus,
  output logic [7:0]  req_devfn,
  output logic [7:0]  req_offset,
  output logic [3:0]  req_be,
  output logic [31:0] req_wdata,
  input  logic [31:0] req_rdata,
  input  logic        tgt_present,
  input  logic        tgt_powered,
  input  logic        tgt_fn0_present
);
  localparam logic [8:0] LIMIT = 9'(SPACE_BYTES);

  logic [31:0] ptr_q;
  logic        ptr_wr;
  logic [1:0]  lane;
  logic [8:0]  remain;
  logic        in_range, size_ok, exposed, grant;
  logic [2:0]  len;
  logic [3:0]  mask;

  // pointer register
  assign ptr_wr = hb_valid & ~hb_sel & hb_write & (hb_off == 2'd0) & (hb_size == 3'd4);

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_wr) ptr_q <= hb_wdata;
  end

  // request fields
  assign req_bus    = ptr_q[23:16];
  assign req_devfn  = ptr_q[15:8];
  assign req_offset = ptr_q[7:0] | {6'd0, hb_off};
  assign lane       = req_offset[1:0];

  // qualification
  assign in_range = {1'b0, req_offset} < LIMIT;
  assign remain   = LIMIT - {1'b0, req_offset};
  assign size_ok  = (hb_size == 3'd1) | (hb_size == 3'd2) | (hb_size == 3'd4);
  assign exposed  = (req_devfn[2:0] == 3'd0) | tgt_fn0_present;
  assign grant    = ptr_q[31] & size_ok & in_range & tgt_present & tgt_powered & exposed;

  // length clipped at the space limit
  assign len = (remain < {6'd0, hb_size}) ? remain[2:0] : hb_size;

  always_comb begin
    case (len)
      3'd1:    mask = 4'b0001;
      3'd2:    mask = 4'b0011;
      3'd3:    mask = 4'b0111;
      3'd4:    mask = 4'b1111;
      default: mask = 4'b0000;
    endcase
  end

  assign req_be    = mask << lane;
  assign req_wdata = hb_wdata << {lane, 3'b000};
  assign req_write = hb_write;
  assign req_valid = hb_valid & hb_sel & grant;

  // read return, one cycle later
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hb_rvalid <= 1'b0;
      hb_rdata  <= '0;
    end else begin
      hb_rvalid <= hb_valid & ~hb_write;
      if (hb_valid & ~hb_write) begin
        if (!hb_sel)     hb_rdata <= ptr_q;
        else if (grant)  hb_rdata <= req_rdata >> {lane, 3'b000};
        else             hb_rdata <= '1;
      end
    end
  end

  // checks
  a_r1_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(hb_valid && !hb_sel && hb_write && hb_off == 2'd0 && hb_size == 3'd4) |=> $stable(ptr_q));
  a_r3_no_req_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ptr_q[31]);
  a_r3_disabled_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_valid && !hb_write && hb_sel && !ptr_q[31]) |=> (hb_rdata == 32'hFFFF_FFFF));
  a_r5_be_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_be != 4'd0));
  a_r6_rvalid_next: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_valid && !hb_write) |=> hb_rvalid);
  a_r6_no_rvalid_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(hb_valid && !hb_write) |=> !hb_rvalid);
  a_r8_target_ok: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (tgt_present && tgt_powered && (req_devfn[2:0] == 3'd0 || tgt_fn0_present)));
  a_r9_in_limit: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ({1'b0, req_offset} < LIMIT));
endmodule

// File: tb/cfg_window_bridge_bench.sv
module cfg_window_bridge_bench;
  localparam int SPACE = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hb_valid = 1'b0, hb_write = 1'b0, hb_sel = 1'b0;
  logic [1:0] hb_off = '0;
  logic [2:0] hb_size = '0;
  logic [31:0] hb_wdata = '0;
  logic [31:0] hb_rdata, req_wdata, req_rdata;
  logic hb_rvalid, req_valid, req_write;
  logic [7:0] req_bus, req_devfn, req_offset;
  logic [3:0] req_be;
  logic tgt_present, tgt_powered, tgt_fn0_present;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cfg_window_bridge #(.SPACE_BYTES(SPACE)) u_cfg_window_bridge (
    .clk, .rst_n, .hb_valid, .hb_write, .hb_sel, .hb_off, .hb_size, .hb_wdata,
    .hb_rdata, .hb_rvalid, .req_valid, .req_write, .req_bus, .req_devfn,
    .req_offset, .req_be, .req_wdata, .req_rdata, .tgt_present, .tgt_powered,
    .tgt_fn0_present);

  // target stub: bus 2 holds devfn 08, 0B (fn3 of dev1), 10 (unpowered), 1A (fn2, no fn0)
  function automatic bit exists(input logic [7:0] b, input logic [7:0] df);
    return (b == 8'd2) && (df == 8'h08 || df == 8'h0B || df == 8'h10 || df == 8'h1A);
  endfunction
  always_comb begin
    tgt_present     = exists(req_bus, req_devfn);
    tgt_powered     = tgt_present && (req_devfn != 8'h10);
    tgt_fn0_present = exists(req_bus, {req_devfn[7:3], 3'b000});
    req_rdata       = {req_devfn, req_offset & 8'hFC, 8'hC3, 8'h3C};
  end

  logic s_req, s_wr, s_rv;
  logic [7:0] s_bus, s_devfn, s_off;
  logic [3:0] s_be;
  logic [31:0] s_wd, s_tword, s_rd;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic sel, input logic [1:0] off,
                     input logic [2:0] sz, input logic [31:0] wd);
    @(negedge clk);
    hb_valid = 1'b1; hb_write = wr; hb_sel = sel; hb_off = off; hb_size = sz; hb_wdata = wd;
    #1;
    s_req = req_valid; s_wr = req_write; s_bus = req_bus; s_devfn = req_devfn;
    s_off = req_offset; s_be = req_be; s_wd = req_wdata; s_tword = req_rdata;
    @(negedge clk);
    hb_valid = 1'b0;
    s_rv = hb_rvalid; s_rd = hb_rdata;
  endtask

  task automatic set_ptr(input logic [31:0] v);
    acc(1'b1, 1'b0, 2'd0, 3'd4, v);
  endtask

  function automatic logic [3:0] exp_be(input logic [7:0] off, input int sz);
    int len = sz;
    if (SPACE - int'(off) < len) len = SPACE - int'(off);
    return 4'(((1 << len) - 1) << off[1:0]);
  endfunction

  task automatic t_reset();
    chk(hb_rvalid == 1'b0, "R11 rvalid after reset", 32'(hb_rvalid), 0);
    acc(1'b0, 1'b0, 2'd0, 3'd4, 0);
    chk(s_rv && s_rd == 32'h0, "R11 pointer cleared", s_rd, 0);
  endtask

  task automatic t_ptr();
    set_ptr(32'h8002_0810);
    acc(1'b0, 1'b0, 2'd3, 3'd1, 0);
    chk(s_rd == 32'h8002_0810, "R2 pointer read size1 off3", s_rd, 32'h8002_0810);
    acc(1'b1, 1'b0, 2'd0, 3'd2, 32'h1234_5678);
    acc(1'b0, 1'b0, 2'd0, 3'd4, 0);
    chk(s_rd == 32'h8002_0810, "R1 size2 write ignored", s_rd, 32'h8002_0810);
    acc(1'b1, 1'b0, 2'd1, 3'd4, 32'h1234_5678);
    acc(1'b0, 1'b0, 2'd0, 3'd2, 0);
    chk(s_rd == 32'h8002_0810, "R1 offset1 write ignored", s_rd, 32'h8002_0810);
    acc(1'b1, 1'b1, 2'd0, 3'd4, 32'h0000_0000);
    chk(s_rv == 1'b0, "R6 no rvalid on write", 32'(s_rv), 0);
    acc(1'b0, 1'b0, 2'd0, 3'd4, 0);
    chk(s_rd == 32'h8002_0810, "R1 window write leaves pointer", s_rd, 32'h8002_0810);
  endtask

  task automatic t_disabled();
    set_ptr(32'h0002_0810);
    acc(1'b1, 1'b1, 2'd0, 3'd4, 32'hDEAD_BEEF);
    chk(!s_req, "R3 disabled write no request", 32'(s_req), 0);
    acc(1'b0, 1'b1, 2'd1, 3'd1, 0);
    chk(!s_req && s_rv && s_rd == 32'hFFFF_FFFF, "R3 disabled read ones", s_rd, 32'hFFFF_FFFF);
  endtask

  task automatic t_lanes();
    set_ptr(32'h8002_0810);
    for (int l = 0; l < 4; l++) begin
      acc(1'b0, 1'b1, 2'(l), 3'd1, 0);
      chk(s_req && !s_wr && s_bus == 8'd2 && s_devfn == 8'h08 && s_off == 8'(8'h10 + l),
          "R4 fields per lane", {s_bus, s_devfn, s_off, 8'(s_req)}, {8'd2, 8'h08, 8'(8'h10 + l), 8'd1});
      chk(s_be == 4'(1 << l), "R5 single-byte enable", 32'(s_be), 32'(1 << l));
      chk(s_rv && s_rd == (s_tword >> (8 * l)), "R6 read lane data", s_rd, s_tword >> (8 * l));
    end
    acc(1'b1, 1'b1, 2'd2, 3'd2, 32'h0000_ABCD);
    chk(s_req && s_wr && s_be == 4'b1100 && s_wd == 32'hABCD_0000, "R5 write lane2 size2",
        {s_be, s_wd[27:0]}, {4'b1100, 28'hBCD_0000});
    acc(1'b1, 1'b1, 2'd1, 3'd4, 32'h4433_2211);
    chk(s_be == 4'b1110 && s_wd == 32'h3322_1100, "R5 size4 at lane1 truncated", 32'(s_be), 32'b1110);
    set_ptr(32'h8002_0811);
    acc(1'b0, 1'b1, 2'd2, 3'd1, 0);
    chk(s_off == 8'h13 && s_be == 4'b1000, "R4 offset bits ORed", 32'(s_off), 32'h13);
  endtask

  task automatic t_absent();
    set_ptr(32'h8002_3000);
    acc(1'b0, 1'b1, 2'd0, 3'd4, 0);
    chk(!s_req && s_rd == 32'hFFFF_FFFF, "R7 absent read ones", s_rd, 32'hFFFF_FFFF);
    acc(1'b1, 1'b1, 2'd0, 3'd4, 32'h1);
    chk(!s_req, "R7 absent write no request", 32'(s_req), 0);
    set_ptr(32'h8003_0800);
    acc(1'b0, 1'b1, 2'd0, 3'd4, 0);
    chk(!s_req && s_rd == 32'hFFFF_FFFF, "R7 wrong bus read ones", s_rd, 32'hFFFF_FFFF);
  endtask

  task automatic t_unavail();
    set_ptr(32'h8002_1004);
    acc(1'b0, 1'b1, 2'd0, 3'd4, 0);
    chk(!s_req && s_rd == 32'hFFFF_FFFF, "R8 unpowered read ones", s_rd, 32'hFFFF_FFFF);
    acc(1'b1, 1'b1, 2'd0, 3'd4, 32'h5);
    chk(!s_req, "R8 unpowered write no request", 32'(s_req), 0);
    set_ptr(32'h8002_1A04);
    acc(1'b0, 1'b1, 2'd0, 3'd4, 0);
    chk(!s_req && s_rd == 32'hFFFF_FFFF, "R8 hidden function read ones", s_rd, 32'hFFFF_FFFF);
    set_ptr(32'h8002_0B04);
    acc(1'b0, 1'b1, 2'd0, 3'd4, 0);
    chk(s_req && s_rd == s_tword, "R8 exposed function granted", s_rd, s_tword);
  endtask

  task automatic t_limit();
    set_ptr(32'h8002_083C);
    acc(1'b0, 1'b1, 2'd2, 3'd4, 0);
    chk(s_req && s_be == exp_be(8'h3E, 4) && s_be == 4'b1100, "R5 clip at limit size4", 32'(s_be), 32'b1100);
    chk(s_rd == (s_tword >> 16), "R6 clipped read data", s_rd, s_tword >> 16);
    acc(1'b1, 1'b1, 2'd3, 3'd2, 32'h77);
    chk(s_req && s_be == 4'b1000, "R5 clip last byte", 32'(s_be), 32'b1000);
    set_ptr(32'h8002_0840);
    acc(1'b0, 1'b1, 2'd0, 3'd1, 0);
    chk(!s_req && s_rd == 32'hFFFF_FFFF, "R9 offset at limit read ones", s_rd, 32'hFFFF_FFFF);
    set_ptr(32'h8002_08F0);
    acc(1'b1, 1'b1, 2'd1, 3'd4, 32'h9);
    chk(!s_req, "R9 offset past limit write no request", 32'(s_req), 0);
  endtask

  task automatic t_badsize();
    set_ptr(32'h8002_0800);
    acc(1'b0, 1'b1, 2'd0, 3'd3, 0);
    chk(!s_req && s_rd == 32'hFFFF_FFFF, "R10 size3 read ones", s_rd, 32'hFFFF_FFFF);
    acc(1'b1, 1'b1, 2'd0, 3'd0, 32'h1);
    chk(!s_req, "R10 size0 write no request", 32'(s_req), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ptr();
    t_disabled();
    t_lanes();
    t_absent();
    t_unavail();
    t_limit();
    t_badsize();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule